// File: doc/BRIEF.md
# I2C Target with 7-bit Address Matching

This block is the target side of a two-wire serial bus. It watches the clock and data lines of the bus, oversampled by a much faster system clock, and drives the data line only through an open-drain enable. When `sda_oe` is high the pad pulls the data line low; when it is low the line is released to the pull-up. The block detects start, repeated start and stop conditions. It collects the 7-bit address and the direction bit that follow a start, and acknowledges only its own, non-reserved address. It then either takes in write bytes or sends read bytes.

User logic connects through a narrow byte interface. Each received write byte appears on `rx_data` with a one-cycle `rx_valid` strobe. For reads, the block raises `tx_req` for one cycle whenever it needs the next byte, and it samples `tx_data` in that same cycle.

The control is a single state machine with these states:
- `ST_IDLE`: waiting for a start.
- `ST_ADDR`: shifting in the address and direction bit.
- `ST_ADDR_ACK`: driving the address acknowledge.
- `ST_WR_DATA`: shifting in a write byte.
- `ST_WR_ACK`: driving the write acknowledge.
- `ST_RD_LOAD`: fetching the next read byte.
- `ST_RD_DATA`: shifting out a read byte.
- `ST_RD_ACK`: sampling the controller's acknowledge.
- `ST_IGNORE`: off the bus until the next start or stop.

The transitions are as follows:
- A start from any state goes to `ST_ADDR`.
- A stop from any state goes to `ST_IDLE`.
- In `ST_ADDR`, the SCL fall after the 8th bit goes to `ST_ADDR_ACK` on a hit, or to `ST_IGNORE` otherwise.
- In `ST_ADDR_ACK`, an SCL fall goes to `ST_WR_DATA` when writing, or to `ST_RD_LOAD` when reading.
- In `ST_WR_DATA`, the SCL fall after the 8th bit goes to `ST_WR_ACK`.
- In `ST_WR_ACK`, an SCL fall goes back to `ST_WR_DATA`.
- `ST_RD_LOAD` always goes to `ST_RD_DATA` on the next clock.
- In `ST_RD_DATA`, the SCL fall after the 8th bit goes to `ST_RD_ACK`.
- In `ST_RD_ACK`, an SCL fall goes to `ST_RD_LOAD` if the controller acknowledged, or to `ST_IGNORE` if it did not.

Top module: `i2c_tgt`

## Requirements
- R1: After reset, `sda_oe`, `rx_valid` and `tx_req` are all low.
- R2: SDA falling while SCL is high (a start) begins address reception. SDA rising while SCL is high (a stop) returns the block to idle with SDA released.
- R3: The first frame after a start is 7 address bits, MSB first, followed by a direction bit (0 = write, 1 = read). For example, 0x2D with write forms 0x5A. When the address equals `own_addr`, the target holds SDA low throughout the 9th SCL pulse.
- R4: On an address mismatch the target leaves SDA released in the 9th pulse. Until the next start it drives nothing, raises no `rx_valid` and no `tx_req`.
- R5: An address whose upper four bits are 0000 or 1111 is never acknowledged, even when `own_addr` equals it.
- R6: In a write, each 8-bit data frame (MSB first) appears on `rx_data` with a single-cycle `rx_valid` pulse, and the target acknowledges the frame in the following pulse.
- R7: In a read, `tx_req` pulses for one cycle after the address acknowledge and after each controller ACK, and `tx_data` is sampled in that cycle. The byte is driven MSB first.
- R8: After the controller NACKs a read byte, the target keeps SDA released and raises no `tx_req` until the next start.
- R9: A repeated start at any bit position (inside the address or a data byte) aborts the byte without `rx_valid` and restarts address reception.
- R10: SCL and SDA pass a two-flop synchronizer. The target samples SDA on SCL rising and changes `sda_oe` only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 7 | Target address to match |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 = pull data line low |
| rx_data | output | 8 | Last received write byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| tx_data | input | 8 | Next read byte, sampled while `tx_req` is high |
| tx_req | output | 1 | One-cycle request for the next read byte |

## Verification
The assertions assume four things about the inputs:
- Every bus level is held for well over the synchronizer depth plus an edge-detect cycle.
- SDA changes while SCL is high only to form a start or a stop.
- `own_addr` stays stable during a transaction.
- `tx_data` is valid in the `tx_req` cycle.

The bench keeps within these assumptions. Each SCL phase lasts twenty system clocks, and the controller moves SDA only in the middle of the SCL low phase, except for its deliberate start and stop sequences. The bench changes `own_addr` only between a stop and the next start, and loads each read byte one full bit time before it is requested.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int RSV_W  = 4;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_LOAD,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_IGNORE
    } tgt_state_e;

    // Upper address group all-zero or all-one is reserved.
    function automatic logic addr_reserved(input logic [ADDR_W-1:0] a);
        return (a[ADDR_W-1 -: RSV_W] == '0) || (a[ADDR_W-1 -: RSV_W] == '1);
    endfunction

endpackage

// File: rtl/i2c_tgt_sync_cell.sv
module i2c_tgt_sync_cell #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/i2c_tgt_line_mon.sv
module i2c_tgt_line_mon #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    i2c_tgt_sync_cell #(.STAGES(STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s)
    );
    i2c_tgt_sync_cell #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              tx_req
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_W);

    tgt_state_e        state, nxt;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              rw_q;
    logic              mack;
    logic              byte_end;
    logic              addr_hit;

    assign byte_end = scl_fall && (cnt == LAST_CNT);
    assign addr_hit = (shreg[BYTE_W-1:1] == own_addr) &&
                      !addr_reserved(shreg[BYTE_W-1:1]);
    assign tx_req   = (state == ST_RD_LOAD);

    // Next-state decision
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_end) nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) nxt = rw_q ? ST_RD_LOAD : ST_WR_DATA;
                ST_WR_DATA:  if (byte_end) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) nxt = ST_WR_DATA;
                ST_RD_LOAD:  nxt = ST_RD_DATA;
                ST_RD_DATA:  if (byte_end) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) nxt = mack ? ST_RD_LOAD : ST_IGNORE;
                ST_IGNORE:   nxt = ST_IGNORE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            cnt      <= '0;
            rw_q     <= 1'b0;
            mack     <= 1'b0;
            sda_oe   <= 1'b0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (start_det || stop_det) begin
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WR_DATA: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (byte_end) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                rw_q   <= shreg[0];
                                sda_oe <= addr_hit;
                            end else begin
                                rx_data  <= shreg;
                                rx_valid <= 1'b1;
                                sda_oe   <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_WR_ACK: begin
                        if (scl_fall) sda_oe <= 1'b0;
                    end
                    ST_RD_LOAD: begin
                        shreg  <= tx_data;
                        sda_oe <= ~tx_data[BYTE_W-1];
                        cnt    <= '0;
                    end
                    ST_RD_DATA: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (byte_end) begin
                            cnt    <= '0;
                            sda_oe <= 1'b0;
                        end else if (scl_fall) begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~shreg[BYTE_W-2];
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) mack <= ~sda_s;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR)); // R2
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE && !sda_oe)); // R2
    AST_NO_RESERVED_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> (shreg[7:4] != 4'h0 && shreg[7:4] != 4'hF)); // R5
    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!sda_oe && !tx_req)); // R4
    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R6
    AST_TXREQ_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> (rw_q && !sda_oe)); // R7
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det))); // R10
endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_req
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_tgt_line_mon #(.STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_tgt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .own_addr(own_addr),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .tx_data(tx_data),
        .sda_oe(sda_oe), .rx_data(rx_data), .rx_valid(rx_valid), .tx_req(tx_req)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && !rx_valid && !tx_req)); // R1
endmodule

// File: tb/i2c_tgt_tb_top.sv
`timescale 1ns/1ps
module i2c_tgt_tb_top;
    localparam int H = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] own_addr = 7'h2D;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       sda_oe, rx_valid, tx_req;
    logic [7:0] rx_data;
    logic [7:0] tx_data = 8'h00;

    int n_tests = 0;
    int n_fail  = 0;
    int n_txreq = 0;
    int r10_viol = 0;
    bit done = 1'b0;
    logic prev_oe = 1'b0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_tgt dut_i (
        .clk(clk), .rst_n(rst_n), .own_addr(own_addr),
        .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_data(tx_data), .tx_req(tx_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: pops expected write bytes as rx_valid strobes arrive.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected rx_valid", rx_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rx_data == e, "R6 rx byte", rx_data, e);
                end
            end
            if (tx_req) n_txreq++;
            if (scl_m && (sda_oe != prev_oe)) r10_viol++;
        end
        prev_oe <= sda_oe;
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0; wt(H / 2);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wt(H / 2);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0; wt(H / 2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(H / 2);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic bus_bit(input logic b, output logic rd);
        sda_m = b; wt(H / 2);
        scl_m = 1'b1; wt(H / 2);
        rd = sda_bus; wt(H / 2);
        scl_m = 1'b0; wt(H / 2);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
        bus_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic rd_byte(input logic send_ack, input logic [7:0] next_tx, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, r);
            d[i] = r;
        end
        tx_data = next_tx;
        bus_bit(~send_ack, r);
    endtask

    initial begin
        logic ack;
        logic r;
        logic [7:0] d;
        int base;

        wt(4);
        chk(sda_oe == 1'b0 && rx_valid == 1'b0 && tx_req == 1'b0, "R1 reset outputs",
            {sda_oe, rx_valid, tx_req}, 0);
        rst_n = 1'b1;
        wt(10);

        // Write to own address 0x2D: 0x5A then two data bytes
        bus_start();
        exp_q.push_back(8'hA5);
        exp_q.push_back(8'h3C);
        wr_byte(8'h5A, ack); chk(ack, "R3 address ack", ack, 1);
        wr_byte(8'hA5, ack); chk(ack, "R6 data ack 1", ack, 1);
        wr_byte(8'h3C, ack); chk(ack, "R6 data ack 2", ack, 1);
        bus_stop();
        wt(8);
        chk(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);
        chk(exp_q.size() == 0, "R6 all bytes seen", exp_q.size(), 0);

        // Mismatched address 0x2C
        bus_start();
        wr_byte(8'h58, ack); chk(!ack, "R4 mismatch nack", ack, 0);
        wr_byte(8'h00, ack); chk(!ack, "R4 data ignored", ack, 0);
        bus_stop();
        wt(8);

        // Read from 0x2D: three bytes, NACK on the last
        base = n_txreq;
        tx_data = 8'hC3;
        bus_start();
        wr_byte(8'h5B, ack); chk(ack, "R3 read address ack", ack, 1);
        rd_byte(1'b1, 8'h5E, d); chk(d == 8'hC3, "R7 read byte 0", d, 8'hC3);
        rd_byte(1'b1, 8'h81, d); chk(d == 8'h5E, "R7 read byte 1", d, 8'h5E);
        rd_byte(1'b0, 8'hFF, d); chk(d == 8'h81, "R7 read byte 2", d, 8'h81);
        chk(n_txreq - base == 3, "R7 tx_req count", n_txreq - base, 3);
        bus_bit(1'b1, r); bus_bit(1'b1, r);
        chk(r == 1'b1 && sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
        chk(n_txreq - base == 3, "R8 no further tx_req", n_txreq - base, 3);
        bus_stop();
        wt(8);

        // Repeated start inside a data byte, then inside the address
        bus_start();
        wr_byte(8'h5A, ack); chk(ack, "R9 first address ack", ack, 1);
        for (int i = 0; i < 4; i++) bus_bit(1'b1, r);
        bus_rstart();
        for (int i = 0; i < 3; i++) bus_bit(1'b0, r);
        bus_rstart();
        exp_q.push_back(8'h69);
        wr_byte(8'h5A, ack); chk(ack, "R9 address after rstart", ack, 1);
        wr_byte(8'h69, ack); chk(ack, "R9 data after rstart", ack, 1);
        tx_data = 8'h77;
        bus_rstart();
        wr_byte(8'h5B, ack); chk(ack, "R9 direction change ack", ack, 1);
        rd_byte(1'b0, 8'h00, d); chk(d == 8'h77, "R9 read after rstart", d, 8'h77);
        bus_stop();
        wt(8);
        chk(exp_q.size() == 0, "R9 no aborted byte delivered", exp_q.size(), 0);

        // Reserved groups 0000xxx and 1111xxx, plus boundary neighbours
        own_addr = 7'h05;
        bus_start(); wr_byte({7'h05, 1'b0}, ack); bus_stop(); wt(8);
        chk(!ack, "R5 reserved 0000101 nack", ack, 0);
        own_addr = 7'h7A;
        bus_start(); wr_byte({7'h7A, 1'b0}, ack); bus_stop(); wt(8);
        chk(!ack, "R5 reserved 1111010 nack", ack, 0);
        own_addr = 7'h08;
        bus_start(); wr_byte({7'h08, 1'b1}, ack);
        tx_data = 8'h00;
        rd_byte(1'b0, 8'h00, d);
        bus_stop(); wt(8);
        chk(ack, "R5 0001000 acked", ack, 1);
        own_addr = 7'h77;
        bus_start(); wr_byte({7'h77, 1'b0}, ack); bus_stop(); wt(8);
        chk(ack, "R5 1110111 acked", ack, 1);

        chk(r10_viol == 0, "R10 sda_oe stable while SCL high", r10_viol, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule